// File: doc/BRIEF.md
# Microcode RAM Load Sequencer

This block takes a descriptor that has already been decoded and a stream of 32-bit code words. From them it carries out a full microcode installation on a simple write-only register bus. First it sets the instruction-RAM address pointer to the descriptor's start offset. Next it writes each code word to the RAM data register, one bus cycle per word. It then sets the split-RAM control bit. After that it programs every trap register whose descriptor value is nonzero, and it finishes with the error/config register.

The code words enter through a ready/valid port. When the producer has nothing to send, the sequencer waits and no word is lost. A one-cycle `start` begins a load. `busy` stays high while the load runs, and `done` pulses with the final write.

The engine can hold only one resident image at a time. A sticky `loaded` flag records a finished load, and only the reset input clears it. If `start` arrives while `loaded` is set, the sequencer raises an error pulse and makes no writes.

Top module: `ucode_loader`

## Requirements
- R1: While and after reset (rst_n low): `busy`, `done`, `err`, `loaded`, `bus_we` and `code_ready` are all 0.
- R2: A `start` pulse accepted while idle and not loaded begins the load. The first bus write has `bus_sel` = 0 (RAM address register), `bus_idx` = 0, and `bus_wdata` = `desc_ram_offset` zero-extended.
- R3: After the address write come exactly `desc_word_count` writes with `bus_sel` = 1 (RAM data register) and `bus_idx` = 0. They carry the accepted code words in arrival order. A count of zero produces no data writes.
- R4: `code_ready` is high only during the streaming phase. A word transfers on a clock edge where both `code_valid` and `code_ready` are high. A cycle with `code_valid` low produces no bus write and loses no word.
- R5: After the code words comes one write with `bus_sel` = 2 (split control) and `bus_idx` = 0. Its `bus_wdata` bit 0 equals `desc_split` and all other bits are 0.
- R6: Trap slot i is held in `desc_traps[i*32 +: 32]`. Trap writes go to slots in ascending index order. Each nonzero slot i gets one write with `bus_sel` = 3, `bus_idx` = i and the slot value unchanged. A slot holding zero gets no write.
- R7: The last write has `bus_sel` = 4 (config register), `bus_idx` = 0 and `bus_wdata` = `desc_config`. `done` is high for exactly that one cycle, and `busy` is low from that cycle on.
- R8: `loaded` goes high together with `done` and stays high until reset.
- R9: A `start` while idle with `loaded` set makes `err` pulse for one cycle in the following cycle. No bus write occurs and `busy` stays low.
- R10: A `start` while `busy` is high is ignored. The running load completes unchanged and `done` pulses once.
- R11: A reset clears `loaded`, and a following `start` performs a complete new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| start | input | 1 | Begin a load (one-cycle pulse) |
| desc_ram_offset | input | 16 | Instruction-RAM start offset |
| desc_word_count | input | 12 | Number of 32-bit code words |
| desc_split | input | 1 | Image needs per-processor split RAM |
| desc_traps | input | 512 | Sixteen 32-bit trap slot values, slot i at bits i*32 |
| desc_config | input | 32 | Error/config register value |
| code_valid | input | 1 | Code word present |
| code_data | input | 32 | Code word |
| code_ready | output | 1 | Sequencer accepts a code word |
| bus_we | output | 1 | Register write strobe |
| bus_sel | output | 3 | Target register: 0 addr, 1 data, 2 split, 3 trap, 4 config |
| bus_idx | output | 4 | Trap slot index for trap writes, else 0 |
| bus_wdata | output | 32 | Write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completed (one-cycle pulse) |
| err | output | 1 | Load refused because an image is already resident (pulse) |
| loaded | output | 1 | Sticky image-resident flag |

## Verification
The load is run with four patterns, and each separates a different class of fault:
- Five words with bubbles on the valid line and traps in slots 2, 7 and 15. This tells stalls, gaps and sparse trap skipping apart from word loss or duplication.
- An empty image with every trap zero. This exposes off-by-one counting and any write to a zero slot.
- A back-to-back stream with all sixteen traps set. This checks ascending slot order and the index carried on each trap write.
- A start repeated during a load, a start after completion, and a reload after reset. These separate ignored requests, refused requests and the reset-cleared guard.

Every bus write is compared in order against an expected list, so a misplaced, missing or extra write is reported.

// File: rtl/ucode_loader_pkg.sv
package ucode_loader_pkg;

   typedef enum logic [2:0] {
      SEL_ADDR  = 3'd0,
      SEL_DATA  = 3'd1,
      SEL_SPLIT = 3'd2,
      SEL_TRAP  = 3'd3,
      SEL_CFG   = 3'd4
   } reg_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_SPLIT,
      ST_TRAP,
      ST_CFG
   } seq_state_e;

endpackage

// File: rtl/ucode_trap_scan.sv
module ucode_trap_scan #(
   parameter int NSLOT = 16,
   parameter int SW    = 32,
   localparam int IW   = $clog2(NSLOT)
) (
   input  logic [NSLOT*SW-1:0] slots,
   input  logic [IW:0]         from,
   output logic                hit,
   output logic [IW-1:0]       idx
);

   logic [NSLOT-1:0] nz;

   if (NSLOT < 2) begin : g_bad_nslot
      $error("ucode_trap_scan: NSLOT must be at least 2");
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_nz
      assign nz[g] = |slots[g*SW +: SW];
   end

   // lowest nonzero slot at or above 'from'
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (nz[i] && (i >= int'(from))) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/ucode_word_counter.sv
module ucode_word_counter #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] count,
   output logic          last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (step)  count <= count + 1'b1;
   end

   assign last = (count == limit - 1'b1);

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && limit != '0) |-> (count < limit));

endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
   import ucode_loader_pkg::*;
#(
   parameter int RAM_AW = 16,
   parameter int CNT_W  = 12,
   parameter int DW     = 32,
   parameter int NTRAP  = 16,
   localparam int TIW   = $clog2(NTRAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RAM_AW-1:0] desc_ram_offset,
   input  logic [CNT_W-1:0]  desc_word_count,
   input  logic              desc_split,
   input  logic [NTRAP*DW-1:0] desc_traps,
   input  logic [DW-1:0]     desc_config,
   input  logic              code_valid,
   input  logic [DW-1:0]     code_data,
   output logic              code_ready,
   output logic              bus_we,
   output logic [2:0]        bus_sel,
   output logic [TIW-1:0]    bus_idx,
   output logic [DW-1:0]     bus_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              loaded
);

   if (DW < RAM_AW) begin : g_bad_dw
      $error("ucode_loader: DW must cover RAM_AW");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ucode_loader: CNT_W must be positive");
   end

   seq_state_e          state;
   logic [RAM_AW-1:0]   ofs_q;
   logic [CNT_W-1:0]    wc_q;
   logic                split_q;
   logic [NTRAP*DW-1:0] traps_q;
   logic [DW-1:0]       cfg_q;
   logic [TIW:0]        tptr;

   logic                scan_hit;
   logic [TIW-1:0]      scan_idx;
   logic                cnt_step;
   logic                cnt_last;
   logic [CNT_W-1:0]    cnt_val;

   assign busy       = (state != ST_IDLE);
   assign code_ready = (state == ST_DATA);
   assign cnt_step   = (state == ST_DATA) && code_valid;

   ucode_word_counter #(.CW(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state == ST_IDLE),
      .step  (cnt_step),
      .limit (wc_q),
      .count (cnt_val),
      .last  (cnt_last)
   );

   ucode_trap_scan #(.NSLOT(NTRAP), .SW(DW)) u_scan (
      .slots (traps_q),
      .from  (tptr),
      .hit   (scan_hit),
      .idx   (scan_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ofs_q     <= '0;
         wc_q      <= '0;
         split_q   <= 1'b0;
         traps_q   <= '0;
         cfg_q     <= '0;
         tptr      <= '0;
         bus_we    <= 1'b0;
         bus_sel   <= 3'(SEL_ADDR);
         bus_idx   <= '0;
         bus_wdata <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         loaded    <= 1'b0;
      end else begin
         bus_we  <= 1'b0;
         bus_idx <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (loaded) begin
                     err <= 1'b1;
                  end else begin
                     ofs_q   <= desc_ram_offset;
                     wc_q    <= desc_word_count;
                     split_q <= desc_split;
                     traps_q <= desc_traps;
                     cfg_q   <= desc_config;
                     state   <= ST_ADDR;
                  end
               end
            end
            ST_ADDR: begin
               bus_we    <= 1'b1;
               bus_sel   <= 3'(SEL_ADDR);
               bus_wdata <= DW'(ofs_q);
               state     <= (wc_q == '0) ? ST_SPLIT : ST_DATA;
            end
            ST_DATA: begin
               if (code_valid) begin
                  bus_we    <= 1'b1;
                  bus_sel   <= 3'(SEL_DATA);
                  bus_wdata <= code_data;
                  if (cnt_last) state <= ST_SPLIT;
               end
            end
            ST_SPLIT: begin
               bus_we    <= 1'b1;
               bus_sel   <= 3'(SEL_SPLIT);
               bus_wdata <= DW'(split_q);
               tptr      <= '0;
               state     <= ST_TRAP;
            end
            ST_TRAP: begin
               if (scan_hit) begin
                  bus_we    <= 1'b1;
                  bus_sel   <= 3'(SEL_TRAP);
                  bus_idx   <= scan_idx;
                  bus_wdata <= traps_q[scan_idx*DW +: DW];
                  tptr      <= {1'b0, scan_idx} + 1'b1;
               end else begin
                  state <= ST_CFG;
               end
            end
            ST_CFG: begin
               bus_we    <= 1'b1;
               bus_sel   <= 3'(SEL_CFG);
               bus_wdata <= cfg_q;
               done      <= 1'b1;
               loaded    <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4
   stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_ready && !code_valid) |=> !bus_we);

   // R9
   refuse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && loaded) |=> (err && !bus_we && !busy));

   // R8
   loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |=> loaded);

   // R6
   trap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_sel == 3'(SEL_TRAP)) |-> (bus_wdata != '0));

   // R7
   done_on_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bus_we && bus_sel == 3'(SEL_CFG) && !busy));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/ucode_loader_test.sv
module ucode_loader_test;

   localparam int CLK_P = 10;

   typedef struct {
      logic [2:0]  sel;
      logic [3:0]  idx;
      logic [31:0] data;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [15:0]   desc_ram_offset = '0;
   logic [11:0]   desc_word_count = '0;
   logic          desc_split = 1'b0;
   logic [511:0]  desc_traps = '0;
   logic [31:0]   desc_config = '0;
   logic          code_valid = 1'b0;
   logic [31:0]   code_data = '0;
   logic          code_ready;
   logic          bus_we;
   logic [2:0]    bus_sel;
   logic [3:0]    bus_idx;
   logic [31:0]   bus_wdata;
   logic          busy, done, err, loaded;

   int checks = 0;
   int errors = 0;
   int done_seen = 0;
   exp_t q[$];

   always #(CLK_P/2) clk = ~clk;

   ucode_loader uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .desc_ram_offset(desc_ram_offset), .desc_word_count(desc_word_count),
      .desc_split(desc_split), .desc_traps(desc_traps), .desc_config(desc_config),
      .code_valid(code_valid), .code_data(code_data), .code_ready(code_ready),
      .bus_we(bus_we), .bus_sel(bus_sel), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
      .busy(busy), .done(done), .err(err), .loaded(loaded)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] sel, input logic [3:0] idx,
                       input logic [31:0] data, input string tag);
      exp_t e;
      e.sel = sel; e.idx = idx; e.data = data; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: every bus write is compared against the expected queue
   always @(negedge clk) begin
      if (rst_n && bus_we) begin
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL R9 or R10 unexpected write actual=%0d/%0d/%h expected=none",
                     bus_sel, bus_idx, bus_wdata);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (bus_sel !== e.sel || bus_idx !== e.idx || bus_wdata !== e.data) begin
               errors++;
               $display("FAIL %s actual=%0d/%0d/%h expected=%0d/%0d/%h",
                        e.tag, bus_sel, bus_idx, bus_wdata, e.sel, e.idx, e.data);
            end
         end
      end
      if (rst_n && done) done_seen++;
   end

   function automatic logic [31:0] word_of(input int k, input logic [31:0] base);
      return base ^ (32'h0101_0101 * k);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1
      chk(!busy && !done && !err && !loaded && !bus_we && !code_ready, "R1 reset state",
          {26'b0, busy, done, err, loaded, bus_we, code_ready}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic run_load(input logic [15:0] ofs, input int n, input bit split,
                           input logic [511:0] traps, input logic [31:0] cfg,
                           input logic [31:0] base, input bit gaps, input bit poke);
      int cyc = 0;
      int k = 0;
      int t = 0;
      bit poked = 0;
      bit acc;
      push(3'd0, 4'd0, {16'h0, ofs}, "R2 address write");
      for (int i = 0; i < n; i++) push(3'd1, 4'd0, word_of(i, base), "R3 data write");
      push(3'd2, 4'd0, {31'h0, split}, "R5 split write");
      for (int i = 0; i < 16; i++)
         if (traps[i*32 +: 32] != 0) push(3'd3, 4'(i), traps[i*32 +: 32], "R6 trap write");
      push(3'd4, 4'd0, cfg, "R7 config write");
      done_seen = 0;
      @(negedge clk);
      desc_ram_offset = ofs; desc_word_count = 12'(n); desc_split = split;
      desc_traps = traps; desc_config = cfg;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (k < n) begin
         code_valid = !(gaps && (cyc % 3 == 1));
         code_data  = code_valid ? word_of(k, base) : 32'hDEAD_BEEF;
         start      = poke && k == 2 && !poked;
         if (start) poked = 1;
         cyc++;
         #1;
         acc = code_valid && code_ready;
         @(posedge clk);
         if (acc) k++;
         @(negedge clk);
         start = 1'b0;
      end
      code_valid = 1'b0;
      while (!done && t < 200) begin
         @(negedge clk);
         t++;
      end
      // R7
      chk(done === 1'b1 && !busy, "R7 done with busy low", {30'b0, done, busy}, 32'h2);
      // R8
      chk(loaded === 1'b1, "R8 loaded set at completion", {31'b0, loaded}, 32'h1);
      repeat (3) @(negedge clk);
      // R6 / R7: all expected writes consumed
      chk(q.size() == 0, "R6 R7 all writes seen", q.size(), 0);
      // R10: exactly one done
      chk(done_seen == 1, "R10 single done", done_seen, 1);
      // R8 sticky
      chk(loaded === 1'b1 && !done, "R8 loaded stays", {30'b0, loaded, done}, 32'h2);
      q.delete();
   endtask

   initial begin
      repeat (1000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [511:0] tr;
      do_reset();
      // R4: idle, ready low
      @(negedge clk);
      chk(!code_ready && !busy, "R4 ready low when idle", {30'b0, code_ready, busy}, 0);

      // pattern A: gaps, sparse traps, second start mid-load (R10)
      tr = '0;
      tr[2*32 +: 32]  = 32'h0000_8123;
      tr[7*32 +: 32]  = 32'h8000_0001;
      tr[15*32 +: 32] = 32'hFFFF_FFFF;
      run_load(16'h0040, 5, 1'b1, tr, 32'hA5A5_0001, 32'h1234_5678, 1'b1, 1'b1);

      // R9: refused reload
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err === 1'b1 && !busy, "R9 err pulse", {30'b0, err, busy}, 32'h2);
      @(negedge clk);
      chk(err === 1'b0 && !busy && loaded, "R9 err single cycle", {29'b0, err, busy, loaded}, 32'h1);
      repeat (3) @(negedge clk);

      // R11: reset then pattern B (empty image, zero traps)
      do_reset();
      chk(loaded === 1'b0, "R11 loaded cleared", {31'b0, loaded}, 0);
      run_load(16'hFFFF, 0, 1'b0, '0, 32'h0000_0000, 32'h0, 1'b0, 1'b0);

      // pattern C: back-to-back stream, all sixteen traps
      do_reset();
      for (int i = 0; i < 16; i++) tr[i*32 +: 32] = 32'h7000_0000 + 32'(i) + 1;
      run_load(16'h0100, 3, 1'b0, tr, 32'h0F0F_F0F0, 32'hCAFE_0000, 1'b0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule